// File: doc/BRIEF.md
# All-Frame-Mode Counter Controller

This block tracks when a paging-protocol decoder must stay awake for every frame. It holds one all-frame counter and sixteen temporary-address enable counters, each seven bits wide. Only the decoder side can raise a counter. It does so through single-cycle strobes: one strobe per temporary address when a short instruction vector assigns that address, and one shared strobe when an alphanumeric, hex/binary or secure vector arrives. Only the host can lower a counter. It does so by writing a 32-bit control packet.

A packet counts only when its top byte carries the identifier 0x03. In such a packet, one bit lowers the all-frame counter, one bit sets or clears a latched force request, and the low sixteen bits form a bitmap that lowers the matching address counters. Two outputs are driven from registered state. The first is a per-address enable vector, high wherever a counter is nonzero. The second is an all-frame flag, which the rest of the decoder uses to decide whether it may skip frames.

Top module: `frame_mode_ctrl`

## Requirements
- R1: After reset (rst_n low), all counters and the force latch are zero, and both taddr_en and all_frame read zero.
- R2: A high inc_taddr[i] raises address counter i by one at the next clock edge, so taddr_en[i] is high from the cycle after its first increment.
- R3: Every counter stops at 127 and never wraps. After 130 increments, 126 decrements leave the counter enabled and the 127th decrement disables it.
- R4: A counter at zero stays at zero when it is decremented. A later single increment therefore enables it, and a single decrement disables it again.
- R5: A packet is accepted only when pkt_valid is high and pkt_data[31:24] equals 0x03. A packet with any other identifier changes no counter and leaves the force latch unchanged.
- R6: In an accepted packet, pkt_data[23] set lowers the all-frame counter by one. When that bit is clear, the all-frame counter keeps its value.
- R7: In an accepted packet, pkt_data[22] is loaded into the force latch. The latch holds its value until the next accepted packet. pkt_data[21:16] are reserved and have no effect.
- R8: In an accepted packet, each set bit pkt_data[i] (i from 0 to 15) lowers address counter i by one. Each clear bit leaves that counter alone.
- R9: When an increment and an accepted decrement reach the same counter in one cycle, that counter keeps its value.
- R10: all_frame is high exactly when the force latch is set, or the all-frame counter is nonzero, or any address counter is nonzero.
- R11: While dec_off is high, every counter and the force latch are held at zero, and increments and packets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_off | input | 1 | Decoder switched off; holds all state cleared |
| inc_taddr | input | 16 | Per-address increment strobes from the vector parser |
| inc_all | input | 1 | All-frame counter increment strobe |
| pkt_valid | input | 1 | Host packet present this cycle |
| pkt_data | input | 32 | Host control packet |
| taddr_en | output | 16 | Per-address enable, high where the counter is nonzero |
| all_frame | output | 1 | All-frame mode flag |

## Verification
The assertions assume that every input is sampled once per clock. They also assume that a strobe or packet held high for several cycles counts once per cycle, and that pkt_data is ignored while pkt_valid is low. The stimulus drives every input on the falling edge and holds it through exactly one rising edge, so each request is applied in exactly one cycle. The sweeps include cycles where an increment and a decrement reach the same counter together, packets whose identifier is not 0x03, and increments issued while dec_off is high. This exercises the cases the counter assertions separate: saturation, floor, simultaneous hold and forced clear.

// File: rtl/fmc_pkg.sv
package fmc_pkg;
    localparam int PKT_W    = 32;
    localparam int MAP_W    = 16;
    localparam logic [7:0] CTRL_ID = 8'h03;
    localparam int ID_LSB   = 24;
    localparam int DECA_BIT = 23;
    localparam int FORCE_BIT = 22;

    typedef struct packed {
        logic             hit;
        logic             dec_all;
        logic             force_v;
        logic [MAP_W-1:0] dec_map;
    } fmc_cmd_t;
endpackage

// File: rtl/fmc_pkt_decode.sv
module fmc_pkt_decode
    import fmc_pkg::*;
(
    input  logic             pkt_valid,
    input  logic [PKT_W-1:0] pkt_data,
    output fmc_cmd_t         cmd
);
    always_comb begin
        cmd         = '0;
        cmd.hit     = pkt_valid && (pkt_data[PKT_W-1:ID_LSB] == CTRL_ID);
        if (cmd.hit) begin
            cmd.dec_all = pkt_data[DECA_BIT];
            cmd.force_v = pkt_data[FORCE_BIT];
            cmd.dec_map = pkt_data[MAP_W-1:0];
        end
    end
endmodule

// File: rtl/fmc_sat_cnt.sv
module fmc_sat_cnt #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] cnt,
    output logic         nz
);
    localparam logic [W-1:0] CMAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.cnt = '0;
        end else if (inc && !dec) begin
            if (st_q.cnt != CMAX) st_d.cnt = st_q.cnt + 1'b1;
        end else if (dec && !inc) begin
            if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign nz  = (st_q.cnt != '0);

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && cnt != CMAX) |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && !dec && cnt == CMAX) |=> (cnt == CMAX)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && dec && !inc && cnt == '0) |=> (cnt == '0)); // R4
    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc && dec) |=> $stable(cnt)); // R9
    AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !nz); // R11
endmodule

// File: rtl/frame_mode_ctrl.sv
module frame_mode_ctrl
    import fmc_pkg::*;
#(
    parameter int N_TADDR = 16,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_off,
    input  logic [N_TADDR-1:0] inc_taddr,
    input  logic               inc_all,
    input  logic               pkt_valid,
    input  logic [PKT_W-1:0]   pkt_data,
    output logic [N_TADDR-1:0] taddr_en,
    output logic               all_frame
);
    typedef struct packed {
        logic force_on;
    } mode_st_t;

    fmc_cmd_t     cmd;
    mode_st_t     st_d, st_q;
    logic         all_nz;
    logic [CNT_W-1:0] all_cnt;
    logic [CNT_W-1:0] ta_cnt [N_TADDR];

    fmc_pkt_decode u_dec (
        .pkt_valid (pkt_valid),
        .pkt_data  (pkt_data),
        .cmd       (cmd)
    );

    for (genvar gi = 0; gi < N_TADDR; gi++) begin : g_ta
        fmc_sat_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (dec_off),
            .inc   (inc_taddr[gi]),
            .dec   (cmd.dec_map[gi]),
            .cnt   (ta_cnt[gi]),
            .nz    (taddr_en[gi])
        );
    end

    fmc_sat_cnt #(.W(CNT_W)) u_all_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (dec_off),
        .inc   (inc_all),
        .dec   (cmd.dec_all),
        .cnt   (all_cnt),
        .nz    (all_nz)
    );

    always_comb begin
        st_d = st_q;
        if (dec_off)      st_d.force_on = 1'b0;
        else if (cmd.hit) st_d.force_on = cmd.force_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign all_frame = st_q.force_on || all_nz || (|taddr_en);

    AST_FOREIGN_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_off && pkt_valid && pkt_data[PKT_W-1:ID_LSB] != CTRL_ID)
        |=> $stable(st_q.force_on)); // R5
    AST_FORCE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_off && pkt_valid && pkt_data[PKT_W-1:ID_LSB] == CTRL_ID)
        |=> (st_q.force_on == $past(pkt_data[FORCE_BIT]))); // R7
    AST_MODE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.force_on |-> all_frame); // R10
    AST_OFF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dec_off |=> (!all_frame && taddr_en == '0)); // R11
    AST_ALL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_off && !inc_all && cmd.dec_all && all_cnt != '0)
        |=> (all_cnt == $past(all_cnt) - 1'b1)); // R6
    AST_MAP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec_off && !inc_taddr[0] && cmd.dec_map[0] && ta_cnt[0] != '0)
        |=> (ta_cnt[0] == $past(ta_cnt[0]) - 1'b1)); // R8
endmodule

// File: tb/frame_mode_ctrl_bench.sv
module frame_mode_ctrl_bench;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_off = 1'b0;
    logic [N-1:0] inc_taddr = '0;
    logic inc_all = 1'b0;
    logic pkt_valid = 1'b0;
    logic [31:0] pkt_data = '0;
    logic [N-1:0] taddr_en;
    logic all_frame;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_ta [N];
    int m_all = 0;
    bit m_force = 0;

    always #2 clk = ~clk;

    frame_mode_ctrl u_frame_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .dec_off(dec_off), .inc_taddr(inc_taddr),
        .inc_all(inc_all), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .taddr_en(taddr_en), .all_frame(all_frame)
    );

    function automatic int upd(int c, bit inc, bit dec);
        if (inc && !dec) return (c < 127) ? c + 1 : 127;
        if (dec && !inc) return (c > 0) ? c - 1 : 0;
        return c;
    endfunction

    task automatic check(string tag);
        logic [N-1:0] exp_en = '0;
        logic exp_af;
        for (int i = 0; i < N; i++) exp_en[i] = (m_ta[i] != 0);
        exp_af = m_force || (m_all != 0) || (exp_en != '0);
        checks++;
        if (taddr_en !== exp_en || all_frame !== exp_af) begin
            errors++;
            $display("FAIL %s: en=%h af=%b expected en=%h af=%b",
                     tag, taddr_en, all_frame, exp_en, exp_af);
        end
    endtask

    task automatic cyc(logic [N-1:0] it, logic ia, logic pv, logic [31:0] pd,
                       logic off, string tag);
        bit hit;
        @(negedge clk);
        inc_taddr = it; inc_all = ia; pkt_valid = pv; pkt_data = pd; dec_off = off;
        @(posedge clk);
        hit = pv && (pd[31:24] == 8'h03);
        for (int i = 0; i < N; i++)
            m_ta[i] = off ? 0 : upd(m_ta[i], it[i], hit && pd[i]);
        m_all = off ? 0 : upd(m_all, ia, hit && pd[23]);
        if (off) m_force = 0;
        else if (hit) m_force = pd[22];
        #1;
        check(tag);
    endtask

    function automatic logic [31:0] pkt(logic da, logic fo, logic [15:0] map);
        return {8'h03, da, fo, 6'b0, map};
    endfunction

    initial begin
        for (int i = 0; i < N; i++) m_ta[i] = 0;
        #1;
        check("R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #3;
        check("R1 after reset");

        // R2 R3 R8: per address, saturate then drain by bitmap
        for (int i = 0; i < N; i++) begin
            for (int k = 0; k < 130; k++) cyc(N'(1) << i, 0, 0, 0, 0, "R2 R3 increment");
            for (int k = 0; k < 127; k++) cyc(0, 0, 1, pkt(0, 0, 16'(1) << i), 0, "R3 R8 drain");
        end
        // R6: all-frame counter saturate and drain
        for (int k = 0; k < 130; k++) cyc(0, 1, 0, 0, 0, "R3 all inc");
        for (int k = 0; k < 127; k++) cyc(0, 0, 1, pkt(1, 0, 0), 0, "R6 all dec");
        // R4: decrement at floor
        cyc(0, 0, 1, pkt(1, 0, 16'hFFFF), 0, "R4 dec at zero");
        cyc(16'h8001, 1, 0, 0, 0, "R4 inc after floor");
        cyc(0, 0, 1, pkt(1, 0, 16'h8001), 0, "R4 single dec");
        // R5: every foreign identifier ignored
        cyc(16'hFFFF, 1, 0, 0, 0, "R5 preload");
        for (int id = 0; id < 256; id++)
            if (id != 3) cyc(0, 0, 1, {8'(id), 8'hFF, 16'hFFFF}, 0, "R5 foreign id");
        cyc(0, 0, 1, pkt(1, 0, 16'hFFFF), 0, "R5 accepted");
        // R7: force latch and reserved bits
        cyc(0, 0, 1, pkt(0, 1, 0), 0, "R7 force set");
        cyc(0, 0, 0, 32'h03000000, 0, "R7 no packet holds");
        cyc(0, 0, 1, {8'h03, 2'b00, 6'h3F, 16'h0}, 0, "R7 force clear reserved");
        // R9: simultaneous increment and decrement
        cyc(16'h00F0, 1, 0, 0, 0, "R9 preload");
        cyc(16'h0FF0, 1, 1, pkt(1, 0, 16'h0FF0), 0, "R9 collide");
        cyc(0, 0, 1, pkt(1, 0, 16'h00F0), 0, "R9 drain");
        // R11: off clears and blocks
        cyc(16'hFFFF, 1, 1, pkt(0, 1, 0), 0, "R11 preload");
        cyc(16'hFFFF, 1, 1, pkt(0, 1, 0), 1, "R11 off");
        cyc(16'hFFFF, 1, 0, 0, 1, "R11 off inc");
        cyc(0, 0, 0, 0, 0, "R11 after off");
        // R10: mixed sweep
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] pd = $urandom;
            if (k % 3 != 0) pd[31:24] = 8'h03;
            cyc(16'($urandom) & 16'($urandom), ($urandom % 4) == 0, $urandom % 2,
                pd, ($urandom % 200) == 0, "R10 mixed");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule